// File: doc/BRIEF.md
# Timer output-compare reference generator

This block is a single compare channel of a general-purpose timer. Every clock it looks at the timer count supplied from outside, the direction that count is moving in and the channel's active compare value. From these it works out a one-bit reference level that later stages shape into a pin signal. A four-bit mode code picks how the level is formed. The level can be left frozen, set, cleared or toggled when the count equals the compare value. It can be pinned low or high. It can also follow one of two pulse-width rules that change with the count direction.

Software programs the channel through a small write port. One select value loads the compare value. The other loads a control word holding the channel-direction selection, the preload enable, the fast enable, the clear enable and the mode code. With preload on, a new compare value waits in a shadow register until the next update pulse. An external clear input, gated by the clear enable, can hold the level low until an update pulse arrives.

Top module: `ocref_channel`

## Requirements
- R1: While reset is asserted and just after it is released, `ocref` is 0, the active compare value and the control word are all zeros, and the channel is an output in frozen mode.
- R2: A write with `wr_sel`=0 loads the compare value from `wr_data`. A write with `wr_sel`=1 loads the control word from `wr_data`: bits [1:0] are the channel selection, bit 2 is preload enable, bit 3 is fast enable, bit 4 is clear enable, bits [7:5] are mode bits 2..0, and bit 8 is mode bit 3.
- R3: In every cycle the internal reference register takes the level the rules give for the count, direction and active compare value of that cycle. In mode 0 the level keeps its value.
- R4: Mode 1 sets the level to 1 in a cycle where count equals compare. Mode 2 sets it to 0 in such a cycle. In other cycles both modes hold the level.
- R5: Mode 3 inverts the level in every cycle where count equals compare.
- R6: Mode 4 drives the level to 0 and mode 5 drives it to 1, whatever the count.
- R7: Mode 6: when counting up (`cnt_down`=0) the level is 1 if count < compare, else 0. When counting down the level is 0 if count > compare, else 1.
- R8: Mode 7 produces the complement of the level mode 6 would produce for the same count, compare value and direction.
- R9: Any mode code with bit 3 set holds the level.
- R10: A nonzero channel selection turns the channel into an input. The level then holds and no match has effect, whatever the mode.
- R11: With preload enabled, a compare write goes only to the shadow, and the shadow moves to the active value at an `upd_evt` cycle. With preload disabled, a compare write changes the active value at once.
- R12: With clear enable set, a cycle with `ext_clr`=1 forces the level to 0. The level stays 0 until the first `upd_evt` cycle with `ext_clr` low. With clear enable cleared, `ext_clr` has no effect. Clear overrides every mode of an output channel.
- R13: With fast enable cleared, `ocref` shows the reference register, one cycle behind its inputs. With fast enable set, `ocref` shows the level being computed in the current cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt | input | CNT_W | Timer count value |
| cnt_down | input | 1 | 1 when the timer counts down |
| upd_evt | input | 1 | One-cycle update pulse |
| ext_clr | input | 1 | External reference clear request |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the compare value, 1 selects the control word |
| wr_data | input | CNT_W | Write data |
| ocref | output | 1 | Reference level |

## Verification
The bench sweeps the count in both directions across compare values of zero, a middle value and the top of the swept range, for every defined mode. This covers the edges of the pulse-width rules: a design that used `<` where `<=` is needed when counting down would shift the edge by one count, and one that ignored direction would produce the inverted duty near the compare value. Toggle sweeps cross the match point repeatedly, so a missed or doubled inversion shows up as the wrong phase. The bench also holds a compare write back under preload until an update pulse, latches a clear and releases it only on an update, and runs the reserved and input selections, where a design that let a match through would change a held level.

// File: rtl/ocref_pkg.sv
`timescale 1ns/1ps
package ocref_pkg;

  // Width of the control word carried on the write port
  localparam int CTRL_W = 9;

  // Mode codes (bit 3 set means reserved)
  localparam logic [3:0] M_FROZEN = 4'd0;
  localparam logic [3:0] M_SET    = 4'd1;
  localparam logic [3:0] M_CLR    = 4'd2;
  localparam logic [3:0] M_TOG    = 4'd3;
  localparam logic [3:0] M_LOW    = 4'd4;
  localparam logic [3:0] M_HIGH   = 4'd5;
  localparam logic [3:0] M_PWM1   = 4'd6;
  localparam logic [3:0] M_PWM2   = 4'd7;

  typedef struct packed {
    logic [3:0] mode;
    logic       clr_en;
    logic       fast_en;
    logic       pre_en;
    logic [1:0] sel;
  } ctrl_t;

  // Control word layout: sel[1:0], preload 2, fast 3, clear 4,
  // mode[2:0] at [7:5], mode[3] at 8
  function automatic ctrl_t unpack_ctrl(input logic [CTRL_W-1:0] w);
    ctrl_t c;
    c.sel     = w[1:0];
    c.pre_en  = w[2];
    c.fast_en = w[3];
    c.clr_en  = w[4];
    c.mode    = {w[8], w[7:5]};
    return c;
  endfunction

endpackage

// File: rtl/ocref_regs.sv
`timescale 1ns/1ps
module ocref_regs
  import ocref_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             upd_evt,
  output ctrl_t            ctrl,
  output logic [CNT_W-1:0] cmp_act,
  output logic             cmp_wr
);

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] shadow_q;
  logic [CNT_W-1:0] act_q;
  logic             ctrl_wr;

  assign cmp_wr  = wr_en && !wr_sel;
  assign ctrl_wr = wr_en && wr_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_wr) begin
      ctrl_q <= unpack_ctrl(wr_data[CTRL_W-1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_q <= '0;
      act_q    <= '0;
    end else begin
      if (cmp_wr) begin
        shadow_q <= wr_data;
      end
      if (!ctrl_q.pre_en) begin
        if (cmp_wr) begin
          act_q <= wr_data;
        end
      end else if (upd_evt) begin
        act_q <= shadow_q;
      end
    end
  end

  assign ctrl    = ctrl_q;
  assign cmp_act = act_q;

endmodule

// File: rtl/ocref_clear.sv
`timescale 1ns/1ps
module ocref_clear (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_en,
  input  logic ext_clr,
  input  logic upd_evt,
  output logic clr_active
);

  logic clr_q;
  logic clr_req;

  assign clr_req = clr_en && ext_clr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clr_q <= 1'b0;
    end else begin
      clr_q <= (clr_q && !upd_evt) || clr_req;
    end
  end

  assign clr_active = clr_q || clr_req;

endmodule

// File: rtl/ocref_eval.sv
`timescale 1ns/1ps
module ocref_eval
  import ocref_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       mode,
  input  logic [1:0]       sel,
  input  logic             clr_active,
  input  logic [CNT_W-1:0] cnt,
  input  logic             cnt_down,
  input  logic [CNT_W-1:0] cmp,
  output logic             out_mode,
  output logic             match_hit,
  output logic             pwm_lvl,
  output logic             ref_nxt,
  output logic             ref_q
);

  function automatic logic f_match(input logic [CNT_W-1:0] c,
                                   input logic [CNT_W-1:0] k);
    return c == k;
  endfunction

  // Level of the first pulse-width rule
  function automatic logic f_pwm1(input logic [CNT_W-1:0] c,
                                  input logic [CNT_W-1:0] k,
                                  input logic             down);
    return down ? (c <= k) : (c < k);
  endfunction

  assign out_mode  = (sel == 2'b00);
  assign match_hit = out_mode && f_match(cnt, cmp);
  assign pwm_lvl   = f_pwm1(cnt, cmp, cnt_down);

  always_comb begin
    ref_nxt = ref_q;
    if (out_mode) begin
      if (clr_active) begin
        ref_nxt = 1'b0;
      end else if (!mode[3]) begin
        case (mode)
          M_SET:   if (match_hit) ref_nxt = 1'b1;
          M_CLR:   if (match_hit) ref_nxt = 1'b0;
          M_TOG:   if (match_hit) ref_nxt = !ref_q;
          M_LOW:   ref_nxt = 1'b0;
          M_HIGH:  ref_nxt = 1'b1;
          M_PWM1:  ref_nxt = pwm_lvl;
          M_PWM2:  ref_nxt = !pwm_lvl;
          default: ref_nxt = ref_q;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q <= 1'b0;
    end else begin
      ref_q <= ref_nxt;
    end
  end

endmodule

// File: rtl/ocref_channel.sv
`timescale 1ns/1ps
module ocref_channel
  import ocref_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic             cnt_down,
  input  logic             upd_evt,
  input  logic             ext_clr,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic             ocref
);

  ctrl_t            ctrl;
  logic [CNT_W-1:0] cmp_act;
  logic             cmp_wr;
  logic             clr_active;
  logic             out_mode;
  logic             match_hit;
  logic             pwm_lvl;
  logic             ref_nxt;
  logic             ref_q;
  logic [3:0]       mode_q;
  logic             pre_en;

  ocref_regs #(.CNT_W(CNT_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .upd_evt (upd_evt),
    .ctrl    (ctrl),
    .cmp_act (cmp_act),
    .cmp_wr  (cmp_wr)
  );

  ocref_clear u_clear (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_en     (ctrl.clr_en),
    .ext_clr    (ext_clr),
    .upd_evt    (upd_evt),
    .clr_active (clr_active)
  );

  ocref_eval #(.CNT_W(CNT_W)) u_eval (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (ctrl.mode),
    .sel        (ctrl.sel),
    .clr_active (clr_active),
    .cnt        (cnt),
    .cnt_down   (cnt_down),
    .cmp        (cmp_act),
    .out_mode   (out_mode),
    .match_hit  (match_hit),
    .pwm_lvl    (pwm_lvl),
    .ref_nxt    (ref_nxt),
    .ref_q      (ref_q)
  );

  assign mode_q = ctrl.mode;
  assign pre_en = ctrl.pre_en;

  // Fast enable bypasses the reference register
  assign ocref = ctrl.fast_en ? ref_nxt : ref_q;

endmodule

// File: rtl/ocref_channel_chk.sv
`timescale 1ns/1ps
module ocref_channel_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       mode_q,
  input logic             out_mode,
  input logic             clr_active,
  input logic             match_hit,
  input logic             ref_q,
  input logic [CNT_W-1:0] cmp_act,
  input logic             pre_en,
  input logic             upd_evt
);

  a_r3_frozen_holds: assert property (@(posedge clk) disable iff (!rst_n)
    out_mode && mode_q == 4'd0 && !clr_active |=> $stable(ref_q));

  a_r4_set_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q == 4'd1 && match_hit && !clr_active |=> ref_q);

  a_r4_clear_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q == 4'd2 && match_hit && !clr_active |=> !ref_q);

  a_r5_toggle_flips: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q == 4'd3 && match_hit && !clr_active |=> ref_q != $past(ref_q));

  a_r6_force_low: assert property (@(posedge clk) disable iff (!rst_n)
    out_mode && mode_q == 4'd4 |=> !ref_q);

  a_r6_force_high: assert property (@(posedge clk) disable iff (!rst_n)
    out_mode && mode_q == 4'd5 && !clr_active |=> ref_q);

  a_r9_reserved_holds: assert property (@(posedge clk) disable iff (!rst_n)
    out_mode && mode_q[3] && !clr_active |=> $stable(ref_q));

  a_r10_input_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !out_mode |=> $stable(ref_q));

  a_r11_preload_waits: assert property (@(posedge clk) disable iff (!rst_n)
    pre_en && !upd_evt |=> $stable(cmp_act));

  a_r12_clear_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
    out_mode && clr_active |=> !ref_q);

endmodule

bind ocref_channel ocref_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_q     (mode_q),
  .out_mode   (out_mode),
  .clr_active (clr_active),
  .match_hit  (match_hit),
  .ref_q      (ref_q),
  .cmp_act    (cmp_act),
  .pre_en     (pre_en),
  .upd_evt    (upd_evt)
);

// File: tb/ocref_channel_test.sv
`timescale 1ns/1ps
module ocref_channel_test;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] cnt = '0;
  logic         cnt_down = 1'b0;
  logic         upd_evt = 1'b0;
  logic         ext_clr = 1'b0;
  logic         wr_en = 1'b0;
  logic         wr_sel = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic         ocref;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // Bench model state
  logic         m_ref = 0, m_clr = 0;
  logic [W-1:0] m_act = 0, m_shadow = 0;
  logic [3:0]   m_mode = 0;
  logic [1:0]   m_sel = 0;
  logic         m_pre = 0, m_fast = 0, m_clren = 0;

  ocref_channel #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .cnt_down(cnt_down),
    .upd_evt(upd_evt), .ext_clr(ext_clr), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .ocref(ocref)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: ocref=%0b expected %0b (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] ctrl_word(input logic [3:0] md, input logic [1:0] sl,
                                             input logic pre, input logic fst, input logic ce);
    logic [W-1:0] w;
    w = '0;
    w[1:0] = sl; w[2] = pre; w[3] = fst; w[4] = ce;
    w[7:5] = md[2:0]; w[8] = md[3];
    return w;
  endfunction

  // Level the requirements give for one cycle
  function automatic logic model_level(input logic [W-1:0] c, input logic d, input logic x);
    logic lvl, hit, up_hi;
    lvl = m_ref;
    hit = (c == m_act);
    if (d) up_hi = !(c > m_act); else up_hi = (c < m_act);
    if (m_sel != 0) return lvl;
    if (m_clr || (m_clren && x)) return 1'b0;
    if (m_mode[3]) return lvl;
    case (m_mode[2:0])
      3'd1: if (hit) lvl = 1'b1;
      3'd2: if (hit) lvl = 1'b0;
      3'd3: if (hit) lvl = ~lvl;
      3'd4: lvl = 1'b0;
      3'd5: lvl = 1'b1;
      3'd6: lvl = up_hi;
      3'd7: lvl = ~up_hi;
      default: ;
    endcase
    return lvl;
  endfunction

  task automatic step(input logic [W-1:0] c, input logic d, input logic u, input logic x,
                      input logic w, input logic s, input logic [W-1:0] data, input string tag);
    logic nxt;
    @(negedge clk);
    cnt = c; cnt_down = d; upd_evt = u; ext_clr = x;
    wr_en = w; wr_sel = s; wr_data = data;
    #1;
    nxt = model_level(c, d, x);
    if (m_fast) chk(ocref, nxt, {tag, " fast"});
    @(posedge clk);
    m_ref = nxt;
    m_clr = (m_clr && !u) || (m_clren && x);
    if (!m_pre) begin
      if (w && !s) m_act = data;
    end else if (u) begin
      m_act = m_shadow;
    end
    if (w && !s) m_shadow = data;
    if (w && s) begin
      m_sel = data[1:0]; m_pre = data[2]; m_fast = data[3];
      m_clren = data[4]; m_mode = {data[8], data[7:5]};
    end
    #1;
    if (!m_fast) chk(ocref, m_ref, tag);
  endtask

  task automatic wr_ctrl(input logic [W-1:0] wd, input string tag);
    step(cnt, cnt_down, 1'b0, 1'b0, 1'b1, 1'b1, wd, tag);
  endtask

  task automatic wr_cmp(input logic [W-1:0] v, input string tag);
    step(cnt, cnt_down, 1'b0, 1'b0, 1'b1, 1'b0, v, tag);
  endtask

  task automatic sweep(input logic d, input int reps, input string tag);
    for (int r = 0; r < reps; r++) begin
      for (int i = 0; i < 16; i++) begin
        step(d ? W'(15 - i) : W'(i), d, 1'b0, 1'b0, 1'b0, 1'b0, '0, tag);
      end
    end
  endtask

  function automatic string mode_tag(input int md);
    case (md)
      0: return "R3";
      1, 2: return "R4";
      3: return "R5";
      4, 5: return "R6";
      6: return "R7";
      default: return "R8";
    endcase
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(ocref, 1'b0, "R1 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    chk(ocref, 1'b0, "R1 after reset");
    // Frozen after reset: level stays low across a match at compare 0
    sweep(1'b0, 1, "R1");

    // All defined modes, both directions, three compare values (R2 layout)
    for (int md = 0; md < 8; md++) begin
      for (int d = 0; d < 2; d++) begin
        for (int k = 0; k < 3; k++) begin
          wr_ctrl(ctrl_word(((md + d + k) % 2 == 1) ? 4'd5 : 4'd4, 2'd0, 1'b0, 1'b0, 1'b0), "R2");
          wr_cmp((k == 0) ? W'(0) : (k == 1) ? W'(7) : W'(15), "R2");
          wr_ctrl(ctrl_word(4'(md), 2'd0, 1'b0, 1'b0, 1'b0), "R2");
          sweep(1'(d), (md == 3) ? 2 : 1, mode_tag(md));
        end
      end
    end

    // Reserved codes: top mode bit set
    for (int md = 8; md < 16; md++) begin
      wr_ctrl(ctrl_word(4'((md % 2 == 1) ? 5 : 4), 2'd0, 1'b0, 1'b0, 1'b0), "R9");
      wr_cmp(W'(md - 4), "R9");
      wr_ctrl(ctrl_word(4'(md), 2'd0, 1'b0, 1'b0, 1'b0), "R9");
      sweep(1'(md % 2), 1, "R9");
    end

    // Input selections with toggle and force modes
    for (int s = 1; s < 4; s++) begin
      wr_ctrl(ctrl_word(4'd5, 2'd0, 1'b0, 1'b0, 1'b0), "R10");
      wr_cmp(W'(4 * s), "R10");
      wr_ctrl(ctrl_word(4'd3, 2'(s), 1'b0, 1'b0, 1'b0), "R10");
      sweep(1'b0, 1, "R10");
      wr_ctrl(ctrl_word(4'd4, 2'(s), 1'b0, 1'b0, 1'b1), "R10");
      step(W'(3), 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, '0, "R10");
      step(W'(3), 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0, "R10");
    end

    // Preload: new compare waits for the update pulse
    wr_ctrl(ctrl_word(4'd6, 2'd0, 1'b0, 1'b0, 1'b0), "R11");
    wr_cmp(W'(4), "R11");
    wr_ctrl(ctrl_word(4'd6, 2'd0, 1'b1, 1'b0, 1'b0), "R11");
    wr_cmp(W'(12), "R11");
    sweep(1'b0, 1, "R11");
    step(W'(8), 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0, "R11");
    sweep(1'b0, 1, "R11");
    step(W'(2), 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, W'(1), "R11");
    sweep(1'b1, 1, "R11");
    wr_ctrl(ctrl_word(4'd6, 2'd0, 1'b0, 1'b0, 1'b0), "R11");
    wr_cmp(W'(9), "R11");
    sweep(1'b0, 1, "R11");

    // Clear: latch until update, disabled clear has no effect
    wr_ctrl(ctrl_word(4'd5, 2'd0, 1'b0, 1'b0, 1'b0), "R12");
    step(W'(1), 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, '0, "R12");
    step(W'(1), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R12");
    wr_ctrl(ctrl_word(4'd5, 2'd0, 1'b0, 1'b0, 1'b1), "R12");
    step(W'(1), 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, '0, "R12");
    for (int i = 0; i < 4; i++) step(W'(i), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R12");
    step(W'(4), 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, '0, "R12");
    step(W'(5), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R12");
    step(W'(6), 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0, "R12");
    step(W'(7), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R12");
    wr_ctrl(ctrl_word(4'd3, 2'd0, 1'b0, 1'b0, 1'b1), "R12");
    wr_cmp(W'(5), "R12");
    step(W'(5), 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, '0, "R12");
    sweep(1'b0, 1, "R12");
    step(W'(0), 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0, "R12");
    sweep(1'b0, 1, "R12");

    // Fast enable: output shows the level of the current cycle
    wr_ctrl(ctrl_word(4'd6, 2'd0, 1'b0, 1'b1, 1'b0), "R13");
    wr_cmp(W'(6), "R13");
    sweep(1'b0, 1, "R13");
    sweep(1'b1, 1, "R13");
    wr_ctrl(ctrl_word(4'd3, 2'd0, 1'b0, 1'b1, 1'b0), "R13");
    sweep(1'b0, 2, "R13");
    wr_ctrl(ctrl_word(4'd7, 2'd0, 1'b0, 1'b0, 1'b0), "R13");
    sweep(1'b1, 1, "R13");

    step(W'(0), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R3");
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule